// File: doc/BRIEF.md
# Remapping Cache with Slot Allocator

This block keeps a small set-associative cache of address-remapping entries for a checkpointing memory system built on non-volatile storage. Every entry belongs to one cache-block home address. It carries the committed location, where the data of the last checkpoint lives, and it may also carry an uncommitted location, a spare block-sized slot that takes dirty data produced since that checkpoint. A free-list allocator hands out these spare slots and takes back slots that are released later.

Three kinds of request arrive one at a time. A read lookup is always steered to the committed location. A plain dirty writeback goes to the committed location. A redirected dirty writeback goes to the uncommitted slot, and a slot is allocated the first time one is needed. On a miss the committed location is fetched from a backing mapping table through a request/response port, and the result is installed in the cache. The block cannot evict an entry that still holds an uncommitted slot, and it cannot allocate from an empty free list. In either case it raises a checkpoint request and waits. When the checkpoint is reported done, every uncommitted slot becomes the committed location.

Top module: `remap_cache`

## Requirements
- R1: After reset `req_ready` is 1 and `resp_valid`, `mt_req_valid` and `snap_req` are 0. The free list holds the slots SLOT_BASE+0 up to SLOT_BASE+FREE_DEPTH-1 and hands them out last-in first-out, so the first slot given out is SLOT_BASE+FREE_DEPTH-1.
- R2: A read (`req_op`=0, and also the unused code 3) answers with the committed location of the address and `resp_to_new`=0. If the address is not cached, the committed location is first fetched from the mapping-table port and installed.
- R3: A read of an address whose redirected data is not yet committed still returns the committed location, not the uncommitted slot.
- R4: A plain writeback (`req_op`=1) answers with the committed location and `resp_to_new`=0, and takes no slot from the free list.
- R5: A redirected writeback (`req_op`=2) answers with `resp_to_new`=1. If the entry has no uncommitted slot yet, it pops the top of the free list and records it. If the entry already has one, it returns that same slot again.
- R6: A redirected writeback that needs a slot while the free list is empty raises `snap_req` and holds it until `snap_done`. The request then completes with a slot released in the meantime.
- R7: The victim for a miss is an invalid way first, then a way without an uncommitted slot that was not recently used, then any way without an uncommitted slot. If every way of the set holds an uncommitted slot, `snap_req` is raised and no entry is dropped.
- R8: A `snap_done` pulse while `snap_req` is high makes every uncommitted slot the committed location of its entry. Later reads of those addresses return the former uncommitted slot.
- R9: Only one mapping-table fetch is ever outstanding. `mt_req_valid` stays high with a stable `mt_req_addr` until `mt_resp_valid`, and `req_ready` is 0 for the whole time.
- R10: A slot presented on `rel_valid`/`rel_slot` is pushed onto the free list and is the next slot handed out.
- R11: A request to an address that is already cached issues no mapping-table fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; request accepted on this edge |
| req_op | input | 2 | 0 read, 1 plain writeback, 2 redirected writeback, 3 read |
| req_addr | input | ADDR_W | Home block address |
| resp_valid | output | 1 | One-cycle answer pulse |
| resp_loc | output | LOC_W | Location to which the access is steered |
| resp_to_new | output | 1 | Answer is an uncommitted slot |
| mt_req_valid | output | 1 | Mapping-table fetch outstanding |
| mt_req_addr | output | ADDR_W | Address being fetched |
| mt_resp_valid | input | 1 | Fetch answer present |
| mt_resp_loc | input | LOC_W | Committed location from the table |
| snap_req | output | 1 | Checkpoint needed; block waiting |
| snap_done | input | 1 | Checkpoint taken; commit uncommitted slots |
| rel_valid | input | 1 | Released slot present |
| rel_slot | input | LOC_W | Released slot location |

## Verification
The hardest state to reach is a redirected writeback that hits a committed entry while the free list is empty. To get there, all slots must first be used up, and at least one checkpoint must commit them without releasing any. A directed phase does exactly that: it sends redirects to fresh addresses until the bench's model of the list is empty, and the bench releases slots only inside a checkpoint that finds the list empty. A second directed phase fills one set with pinned entries to force a checkpoint on the victim. A third fills a set with one pinned and one unpinned entry to show that the unpinned one is chosen. A seeded random phase then mixes all three operations over a small address pool, and every answer is compared with a bench model of the committed and pending locations.

// File: rtl/remap_pkg.sv
package remap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_FETCH  = 2'd2,
        ST_SNAP   = 2'd3
    } rc_state_e;

    typedef enum logic [1:0] {
        OP_READ     = 2'd0,
        OP_WB_HOME  = 2'd1,
        OP_WB_REDIR = 2'd2,
        OP_READ_ALT = 2'd3
    } rc_op_e;

    function automatic logic op_is_redirect(input rc_op_e op);
        return op == OP_WB_REDIR;
    endfunction

endpackage

// File: rtl/remap_free_list.sv
module remap_free_list #(
    parameter int LOC_W     = 12,
    parameter int DEPTH     = 8,
    parameter int SLOT_BASE = 'h800
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pop,
    output logic [LOC_W-1:0] top_slot,
    output logic             empty,
    input  logic             push,
    input  logic [LOC_W-1:0] push_slot
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [LOC_W-1:0] stack_q [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] top_idx;
    logic [IDX_W-1:0] push_idx;
    logic             pop_ok;
    logic             push_ok;

    assign empty    = (cnt_q == '0);
    assign top_idx  = IDX_W'(cnt_q - CNT_W'(1));
    assign push_idx = IDX_W'(cnt_q);
    assign top_slot = empty ? '0 : stack_q[top_idx];
    assign pop_ok   = pop && !empty;
    assign push_ok  = push && ((cnt_q != CNT_W'(DEPTH)) || pop_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                stack_q[i] <= LOC_W'(SLOT_BASE + i);
            end
            cnt_q <= CNT_W'(DEPTH);
        end else begin
            if (pop_ok && push_ok) begin
                stack_q[top_idx] <= push_slot;
            end else if (push_ok) begin
                stack_q[push_idx] <= push_slot;
                cnt_q <= cnt_q + CNT_W'(1);
            end else if (pop_ok) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    AST_FL_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(DEPTH)) else $error("free list count overflow"); // R10

    AST_FL_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty) else $error("pop from empty free list"); // R6

endmodule

// File: rtl/remap_victim_sel.sv
module remap_victim_sel #(
    parameter int WAYS = 2,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WAYS-1:0]  way_valid,
    input  logic [WAYS-1:0]  way_pinned,
    input  logic [WAYS-1:0]  way_recent,
    output logic             found,
    output logic [WAY_W-1:0] victim
);
    always_comb begin
        found  = 1'b0;
        victim = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!way_pinned[i]) begin
                found  = 1'b1;
                victim = WAY_W'(i);
            end
        end
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!way_pinned[i] && !way_recent[i]) begin
                victim = WAY_W'(i);
            end
        end
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!way_valid[i]) begin
                found  = 1'b1;
                victim = WAY_W'(i);
            end
        end
    end

    AST_VICTIM_UNPINNED: assert property (@(posedge clk) disable iff (rst)
        found |-> !way_pinned[victim]) else $error("pinned victim"); // R7

    AST_VICTIM_NONE_ALL_PINNED: assert property (@(posedge clk) disable iff (rst)
        !found |-> (&way_pinned)) else $error("victim missed"); // R7

endmodule

// File: rtl/remap_cache.sv
module remap_cache
    import remap_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int LOC_W      = 12,
    parameter int SETS       = 4,
    parameter int WAYS       = 2,
    parameter int FREE_DEPTH = 8,
    parameter int SLOT_BASE  = 'h800
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              resp_valid,
    output logic [LOC_W-1:0]  resp_loc,
    output logic              resp_to_new,
    output logic              mt_req_valid,
    output logic [ADDR_W-1:0] mt_req_addr,
    input  logic              mt_resp_valid,
    input  logic [LOC_W-1:0]  mt_resp_loc,
    output logic              snap_req,
    input  logic              snap_done,
    input  logic              rel_valid,
    input  logic [LOC_W-1:0]  rel_slot
);
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int TAG_W = ADDR_W - SET_W;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    typedef struct packed {
        logic             valid;
        logic             has_new;
        logic             recent;
        logic [TAG_W-1:0] tag;
        logic [LOC_W-1:0] old_loc;
        logic [LOC_W-1:0] new_loc;
    } entry_t;

    entry_t            tbl_q [SETS][WAYS];
    rc_state_e         state_q;
    rc_op_e            op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WAY_W-1:0]  vic_q;

    logic [SET_W-1:0]  set_q;
    logic [TAG_W-1:0]  tag_q;
    logic [WAYS-1:0]   hit_vec;
    logic [WAYS-1:0]   val_vec;
    logic [WAYS-1:0]   pin_vec;
    logic [WAYS-1:0]   rec_vec;
    logic [WAYS-1:0]   rec_next;
    logic [WAY_W-1:0]  hit_way;
    logic              hit;
    entry_t            hit_ent;
    logic              is_redir;
    logic              need_alloc;
    logic              fl_pop;
    logic              fl_empty;
    logic [LOC_W-1:0]  fl_top;
    logic              vic_found;
    logic [WAY_W-1:0]  vic_way;

    assign set_q    = SET_W'(addr_q);
    assign tag_q    = addr_q[ADDR_W-1:ADDR_W-TAG_W];
    assign is_redir = op_is_redirect(op_q);

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            val_vec[w] = tbl_q[set_q][w].valid;
            pin_vec[w] = tbl_q[set_q][w].valid && tbl_q[set_q][w].has_new;
            rec_vec[w] = tbl_q[set_q][w].valid && tbl_q[set_q][w].recent;
            hit_vec[w] = tbl_q[set_q][w].valid && (tbl_q[set_q][w].tag == tag_q);
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit     = |hit_vec;
    assign hit_ent = tbl_q[set_q][hit_way];

    always_comb begin
        rec_next = rec_vec | (WAYS'(1) << hit_way);
        if (&rec_next) rec_next = WAYS'(1) << hit_way;
    end

    assign need_alloc = hit && is_redir && !hit_ent.has_new;
    assign fl_pop     = (state_q == ST_LOOKUP) && need_alloc && !fl_empty;

    remap_free_list #(
        .LOC_W     (LOC_W),
        .DEPTH     (FREE_DEPTH),
        .SLOT_BASE (SLOT_BASE)
    ) free_list_i (
        .clk       (clk),
        .rst       (rst),
        .pop       (fl_pop),
        .top_slot  (fl_top),
        .empty     (fl_empty),
        .push      (rel_valid),
        .push_slot (rel_slot)
    );

    remap_victim_sel #(
        .WAYS (WAYS)
    ) victim_sel_i (
        .clk        (clk),
        .rst        (rst),
        .way_valid  (val_vec),
        .way_pinned (pin_vec),
        .way_recent (rec_vec),
        .found      (vic_found),
        .victim     (vic_way)
    );

    assign req_ready    = (state_q == ST_IDLE);
    assign mt_req_valid = (state_q == ST_FETCH);
    assign mt_req_addr  = addr_q;
    assign snap_req     = (state_q == ST_SNAP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            op_q        <= OP_READ;
            addr_q      <= '0;
            vic_q       <= '0;
            resp_valid  <= 1'b0;
            resp_loc    <= '0;
            resp_to_new <= 1'b0;
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    tbl_q[s][w] <= '0;
                end
            end
        end else begin
            resp_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        op_q    <= rc_op_e'(req_op);
                        addr_q  <= req_addr;
                        state_q <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    if (hit) begin
                        if (need_alloc && fl_empty) begin
                            state_q <= ST_SNAP;
                        end else begin
                            resp_valid  <= 1'b1;
                            resp_to_new <= is_redir;
                            if (!is_redir) begin
                                resp_loc <= hit_ent.old_loc;
                            end else if (hit_ent.has_new) begin
                                resp_loc <= hit_ent.new_loc;
                            end else begin
                                resp_loc <= fl_top;
                            end
                            if (need_alloc) begin
                                tbl_q[set_q][hit_way].has_new <= 1'b1;
                                tbl_q[set_q][hit_way].new_loc <= fl_top;
                            end
                            for (int w = 0; w < WAYS; w++) begin
                                tbl_q[set_q][w].recent <= rec_next[w];
                            end
                            state_q <= ST_IDLE;
                        end
                    end else if (vic_found) begin
                        vic_q   <= vic_way;
                        state_q <= ST_FETCH;
                    end else begin
                        state_q <= ST_SNAP;
                    end
                end
                ST_FETCH: begin
                    if (mt_resp_valid) begin
                        tbl_q[set_q][vic_q].valid   <= 1'b1;
                        tbl_q[set_q][vic_q].has_new <= 1'b0;
                        tbl_q[set_q][vic_q].recent  <= 1'b0;
                        tbl_q[set_q][vic_q].tag     <= tag_q;
                        tbl_q[set_q][vic_q].old_loc <= mt_resp_loc;
                        tbl_q[set_q][vic_q].new_loc <= '0;
                        state_q <= ST_LOOKUP;
                    end
                end
                ST_SNAP: begin
                    if (snap_done) begin
                        for (int s = 0; s < SETS; s++) begin
                            for (int w = 0; w < WAYS; w++) begin
                                if (tbl_q[s][w].valid && tbl_q[s][w].has_new) begin
                                    tbl_q[s][w].old_loc <= tbl_q[s][w].new_loc;
                                    tbl_q[s][w].has_new <= 1'b0;
                                end
                            end
                        end
                        state_q <= ST_LOOKUP;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_ONE_FETCH_HELD: assert property (@(posedge clk) disable iff (rst)
        (mt_req_valid && !mt_resp_valid) |=> (mt_req_valid && $stable(mt_req_addr)))
        else $error("fetch dropped or address moved"); // R9

    AST_NO_ACCEPT_IN_FETCH: assert property (@(posedge clk) disable iff (rst)
        mt_req_valid |-> !req_ready) else $error("accept during fetch"); // R9

    AST_SNAP_HELD: assert property (@(posedge clk) disable iff (rst)
        (snap_req && !snap_done) |=> snap_req) else $error("snapshot request dropped"); // R6

    AST_INSTALL_NOT_PINNED: assert property (@(posedge clk) disable iff (rst)
        (mt_req_valid && mt_resp_valid) |-> !(tbl_q[set_q][vic_q].valid && tbl_q[set_q][vic_q].has_new))
        else $error("pinned entry overwritten"); // R7

    AST_RESP_NOT_DURING_FETCH: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> !mt_req_valid) else $error("answer with fetch outstanding"); // R2

endmodule

// File: tb/remap_cache_tb_top.sv
module remap_cache_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 10;
    localparam int LOC_W      = 12;
    localparam int FREE_DEPTH = 8;
    localparam int SLOT_BASE  = 'h800;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_op = 2'd0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              resp_valid;
    logic [LOC_W-1:0]  resp_loc;
    logic              resp_to_new;
    logic              mt_req_valid;
    logic [ADDR_W-1:0] mt_req_addr;
    logic              mt_resp_valid = 1'b0;
    logic [LOC_W-1:0]  mt_resp_loc = '0;
    logic              snap_req;
    logic              snap_done = 1'b0;
    logic              rel_valid = 1'b0;
    logic [LOC_W-1:0]  rel_slot = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    remap_cache #(
        .ADDR_W (ADDR_W), .LOC_W (LOC_W), .SETS (4), .WAYS (2),
        .FREE_DEPTH (FREE_DEPTH), .SLOT_BASE (SLOT_BASE)
    ) dut_i (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_ready (req_ready), .req_op (req_op), .req_addr (req_addr),
        .resp_valid (resp_valid), .resp_loc (resp_loc), .resp_to_new (resp_to_new),
        .mt_req_valid (mt_req_valid), .mt_req_addr (mt_req_addr),
        .mt_resp_valid (mt_resp_valid), .mt_resp_loc (mt_resp_loc),
        .snap_req (snap_req), .snap_done (snap_done),
        .rel_valid (rel_valid), .rel_slot (rel_slot)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [LOC_W-1:0] committed [logic [ADDR_W-1:0]];
    logic [LOC_W-1:0] pending   [logic [ADDR_W-1:0]];
    logic [LOC_W-1:0] fl_model  [$];
    int               rel_counter = 0;

    int               last_snaps;
    int               last_fetches;
    logic [LOC_W-1:0] last_loc;
    logic             last_new;

    task automatic check(input bit ok, input string tag, input int actual, input int expected);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
        end
    endtask

    function automatic logic [LOC_W-1:0] model_committed(input logic [ADDR_W-1:0] a);
        if (committed.exists(a)) return committed[a];
        return LOC_W'(a);
    endfunction

    task automatic handle_snapshot();
        foreach (pending[a]) committed[a] = pending[a];
        pending.delete();
        if (fl_model.size() == 0) begin
            for (int k = 0; k < 2; k++) begin
                rel_valid = 1'b1;
                rel_slot  = LOC_W'('hA00 + rel_counter);
                fl_model.push_back(rel_slot);
                rel_counter++;
                @(negedge clk);
                rel_valid = 1'b0;
            end
        end
        snap_done = 1'b1;
        @(negedge clk);
        snap_done = 1'b0;
    endtask

    // Issue one request, serve the fetch and checkpoint ports, and return the answer.
    task automatic do_op(input logic [1:0] op, input logic [ADDR_W-1:0] addr);
        int guard;
        last_snaps   = 0;
        last_fetches = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = addr;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (1) begin
            guard++;
            if (guard > 2000) begin
                check(1'b0, "R9 op hung", 0, 1);
                break;
            end
            if (resp_valid) begin
                last_loc = resp_loc;
                last_new = resp_to_new;
                break;
            end else if (mt_req_valid) begin
                last_fetches++;
                check(mt_req_addr == addr && !req_ready, "R9 fetch address / ready",
                      int'(mt_req_addr), int'(addr));
                repeat ($urandom_range(0, 3)) @(negedge clk);
                mt_resp_valid = 1'b1;
                mt_resp_loc   = model_committed(addr);
                @(negedge clk);
                mt_resp_valid = 1'b0;
            end else if (snap_req) begin
                last_snaps++;
                handle_snapshot();
            end else begin
                @(negedge clk);
            end
        end
    endtask

    // Expected answer for the op that just finished; updates the model.
    task automatic check_op(input logic [1:0] op, input logic [ADDR_W-1:0] addr, input string tag);
        logic [LOC_W-1:0] exp_loc;
        logic             exp_new;
        if (op == 2'd2) begin
            exp_new = 1'b1;
            if (pending.exists(addr)) begin
                exp_loc = pending[addr];
            end else begin
                exp_loc = fl_model.pop_back();
                pending[addr] = exp_loc;
            end
        end else begin
            exp_new = 1'b0;
            exp_loc = model_committed(addr);
        end
        check(last_loc == exp_loc && last_new == exp_new, tag,
              int'({last_new, last_loc}), int'({exp_new, exp_loc}));
    endtask

    task automatic run(input logic [1:0] op, input logic [ADDR_W-1:0] addr, input string tag);
        do_op(op, addr);
        check_op(op, addr, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_2024));
        for (int i = 0; i < FREE_DEPTH; i++) fl_model.push_back(LOC_W'(SLOT_BASE + i));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 reset req_ready", int'(req_ready), 1);
        check(!resp_valid && !mt_req_valid && !snap_req, "R1 reset outputs idle",
              int'({resp_valid, mt_req_valid, snap_req}), 0);

        // R2: miss fetches committed location
        run(2'd0, 10'h005, "R2 read miss");
        check(last_fetches == 1, "R2 miss fetch count", last_fetches, 1);
        // R11: hit issues no fetch
        run(2'd0, 10'h005, "R11 read hit");
        check(last_fetches == 0, "R11 hit no fetch", last_fetches, 0);
        // R1/R5: first slot is top of free list
        run(2'd2, 10'h005, "R5 redirect allocate");
        check(last_loc == LOC_W'(SLOT_BASE + FREE_DEPTH - 1), "R1 first slot LIFO",
              int'(last_loc), SLOT_BASE + FREE_DEPTH - 1);
        run(2'd2, 10'h005, "R5 redirect reuse");
        // R3: read still sees committed
        run(2'd0, 10'h005, "R3 read after redirect");
        // R4: plain writeback, no allocation
        run(2'd1, 10'h009, "R4 plain writeback");
        run(2'd2, 10'h009, "R4 next redirect shows no slot taken");
        check(last_loc == LOC_W'(SLOT_BASE + FREE_DEPTH - 2), "R4 free list untouched",
              int'(last_loc), SLOT_BASE + FREE_DEPTH - 2);
        // R2: unused op code 3 behaves as read
        run(2'd3, 10'h009, "R2 op code 3 read");

        // R7: preference for unpinned victim (set 2)
        run(2'd2, 10'h002, "R7 pin way");
        run(2'd0, 10'h006, "R7 unpinned fill");
        run(2'd0, 10'h00A, "R7 miss evicts unpinned");
        check(last_snaps == 0, "R7 no checkpoint with unpinned way", last_snaps, 0);
        run(2'd2, 10'h002, "R7 pinned entry kept");
        check(last_fetches == 0, "R7 pinned entry still cached", last_fetches, 0);

        // R7/R8: all ways pinned in set 0 forces a checkpoint
        run(2'd2, 10'h004, "R7 pin set0 a");
        run(2'd2, 10'h008, "R7 pin set0 b");
        run(2'd0, 10'h00C, "R7 miss on full pinned set");
        check(last_snaps == 1, "R7 checkpoint raised", last_snaps, 1);
        run(2'd0, 10'h004, "R8 read after commit");
        run(2'd0, 10'h005, "R8 committed slot read");

        // R6/R10: drain the free list, then force an allocation on empty
        for (int i = 0; i < 64 && fl_model.size() > 0; i++) begin
            run(2'd2, ADDR_W'(10'h040 + i), "R5 drain");
        end
        run(2'd0, 10'h0F1, "R6 prepare committed entry");
        run(2'd2, 10'h0F1, "R6 redirect with empty list");
        check(last_snaps >= 1, "R6 checkpoint on empty list", last_snaps, 1);
        check(last_loc == LOC_W'('hA00 + rel_counter - 1), "R10 released slot handed out",
              int'(last_loc), 'hA00 + rel_counter - 1);

        // random mix over a small address pool
        for (int i = 0; i < 400; i++) begin
            logic [1:0]        op;
            logic [ADDR_W-1:0] a;
            op = 2'($urandom_range(0, 3));
            a  = ADDR_W'($urandom_range(0, 31));
            run(op, a, op == 2'd2 ? "R5 random redirect" :
                       op == 2'd1 ? "R4 random writeback" : "R3 random read");
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule